// File: doc/BRIEF.md
# Hybrid-Integrator Second-Order Delta-Sigma Modulator (Fixed-Point Model)

This block is a synthesizable fixed-point model of a second-order delta-sigma modulator. It is built from two mixed-mode integrators. In each one, a narrow bounded accumulator plays the part of the analog integrator, and a 14-bit wide accumulator plays the part of the digital integrator. Before every update, an overload estimator looks one sample ahead: it adds the stage input to the present bounded value. If that sum would leave the reference range, a fixed correction step is taken out of the bounded path and credited to the wide accumulator of the same stage. The bounded path therefore never saturates, and the excess is carried digitally.

The two stages are cascaded through the bounded path only; there is no global feedback into it. The 1-bit decision is taken from the second bounded accumulator and is used only on the digital side, where it is added as a quantizer level into a registered combined output. Two mode inputs, sampled with each valid sample, control the block:
- `step_double` chooses a correction step of R or 2R.
- `half_level` chooses quantizer levels of ±R or ±R/2.

The reference magnitude R is 2^(BND_W-2), which is 256 with the defaults. The block has no state machine: it holds in one state and steps on each valid sample.

Top module: `hyb_dsm_top`

## Requirements
- R1: For each stage k, let the prediction be P = bounded_k + u_k. The high flag ovl_hi[k] is set when P > R, and the low flag ovl_lo[k] is set when P < -R. The two flags of a stage are never both set. Both flags are registered with the update that used them.
- R2: A stage's correction C is +S when its high flag is predicted, -S when its low flag is predicted, and 0 otherwise. The new bounded value is P - C, and C is added to that stage's wide accumulator.
- R3: Each bounded accumulator (bnd1, bnd2) stays within [-R, +R] after every update. With the defaults, R = 256.
- R4: The step S is R when step_double is 0, and 2R when step_double is 1.
- R5: The stage-1 input is the clamped sample. The stage-2 input is the stage-1 bounded value from before the update. The quantizer decision never enters the bounded path.
- R6: q_bit is 1 when the new bnd2 is ≥ 0, and 0 otherwise. The quantizer level is +L when q_bit is 1 and -L when it is 0. L is R when half_level is 0, and R/2 when half_level is 1.
- R7: A wide accumulator saturates at +8191 or -8192 instead of wrapping. Its wide_ovf bit is set when the unsaturated sum falls outside that range, and the bit stays set until reset.
- R8: combined = wide1 + 2·wide2 + quantizer level. All three terms are taken from the same update, and combined is registered together with them.
- R9: A synchronous reset clears every accumulator, flag and output to zero. When in_valid is low, no output or state changes.
- R10: in_sample is treated as signed and clamped to [-R, +R] before it enters stage 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe; the state advances only when this is high |
| in_sample | input | BND_W | Signed input sample |
| step_double | input | 1 | Correction step select: 0 gives R, 1 gives 2R |
| half_level | input | 1 | Quantizer level select: 0 gives ±R, 1 gives ±R/2 |
| q_bit | output | 1 | 1-bit quantizer decision |
| bnd1 | output | BND_W | Stage-1 bounded accumulator |
| bnd2 | output | BND_W | Stage-2 bounded accumulator |
| wide1 | output | WIDE_W | Stage-1 wide accumulator |
| wide2 | output | WIDE_W | Stage-2 wide accumulator |
| combined | output | WIDE_W+2 | Registered combined output |
| ovl_hi | output | 2 | High-overload flags, one bit per stage |
| ovl_lo | output | 2 | Low-overload flags, one bit per stage |
| wide_ovf | output | 2 | Sticky wide-accumulator overflow bits |

## Verification
The assertions check several properties on every cycle:
- the bounded range and the exclusivity of each stage's flags;
- that the state holds while in_valid is low;
- that the overflow bit stays set once raised, and that a positive correction never makes a wide accumulator fall;
- that q_bit agrees with the sign of bnd2.

Some behaviour can only be shown by the bench scenarios, because it depends on the exact amounts involved: the size of each correction under each step mode, the ±R and ±R/2 quantizer levels, the weighting inside combined, clamping of out-of-range samples, and the exact saturation values. These scenarios are DC inputs at both rails, a full-scale sine, and a sweep over every input code, run under all four mode combinations.

// File: rtl/hyb_pkg.sv
package hyb_pkg;
    // Reference magnitude R for a bounded accumulator of the given width.
    function automatic int ref_mag(input int bnd_w);
        return 1 << (bnd_w - 2);
    endfunction
endpackage

// File: rtl/hyb_bounded_stage.sv
module hyb_bounded_stage
    import hyb_pkg::*;
#(
    parameter int BND_W  = 10,
    parameter int CALC_W = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic signed [CALC_W-1:0] u,
    input  logic                     step_double,
    output logic signed [BND_W-1:0]  acc,
    output logic signed [BND_W-1:0]  acc_nxt,
    output logic signed [CALC_W-1:0] corr,
    output logic                     hi,
    output logic                     lo
);
    localparam int R = ref_mag(BND_W);
    localparam logic signed [CALC_W-1:0] R_C     = CALC_W'(R);
    localparam logic signed [CALC_W-1:0] STEP_1R = CALC_W'(R);
    localparam logic signed [CALC_W-1:0] STEP_2R = CALC_W'(2 * R);
    localparam logic signed [BND_W-1:0]  R_B     = BND_W'(R);

    logic signed [CALC_W-1:0] pred;
    logic signed [CALC_W-1:0] step;
    logic                     hi_c, lo_c;

    // One-sample-ahead overload estimate and correction choice.
    always_comb begin
        pred    = CALC_W'(acc) + u;
        step    = step_double ? STEP_2R : STEP_1R;
        hi_c    = (pred > R_C);
        lo_c    = (pred < -R_C);
        corr    = hi_c ? step : (lo_c ? -step : '0);
        acc_nxt = BND_W'(pred - corr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
            hi  <= 1'b0;
            lo  <= 1'b0;
        end else if (en) begin
            acc <= acc_nxt;
            hi  <= hi_c;
            lo  <= lo_c;
        end
    end

    assert_bounded_R3: assert property (@(posedge clk) disable iff (rst)
        (acc <= R_B) && (acc >= -R_B));
    assert_flags_exclusive_R1: assert property (@(posedge clk) disable iff (rst)
        !(hi && lo));
    assert_hold_bnd_R9: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(acc));
endmodule

// File: rtl/hyb_wide_acc.sv
module hyb_wide_acc #(
    parameter int WIDE_W = 14,
    parameter int CALC_W = 12
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic signed [CALC_W-1:0] corr,
    output logic signed [WIDE_W-1:0] acc,
    output logic signed [WIDE_W-1:0] acc_nxt,
    output logic                     ovf
);
    localparam int SUM_W = WIDE_W + 1;
    localparam logic signed [SUM_W-1:0]  MAX_S = SUM_W'((1 << (WIDE_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0]  MIN_S = -SUM_W'(1 << (WIDE_W - 1));
    localparam logic signed [WIDE_W-1:0] MAX_W = WIDE_W'((1 << (WIDE_W - 1)) - 1);
    localparam logic signed [WIDE_W-1:0] MIN_W = -WIDE_W'(1 << (WIDE_W - 1));

    logic signed [SUM_W-1:0] sum;
    logic                    over_hi, over_lo;

    always_comb begin
        sum     = SUM_W'(acc) + SUM_W'(corr);
        over_hi = (sum > MAX_S);
        over_lo = (sum < MIN_S);
        if (over_hi)      acc_nxt = MAX_W;
        else if (over_lo) acc_nxt = MIN_W;
        else              acc_nxt = WIDE_W'(sum);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
            ovf <= 1'b0;
        end else if (en) begin
            acc <= acc_nxt;
            if (over_hi || over_lo) ovf <= 1'b1;
        end
    end

    assert_sticky_ovf_R7: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);
    assert_no_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (en && (corr > 0)) |=> (acc >= $past(acc)));
    assert_hold_wide_R9: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(acc));
endmodule

// File: rtl/hyb_out_stage.sv
module hyb_out_stage
    import hyb_pkg::*;
#(
    parameter int BND_W  = 10,
    parameter int WIDE_W = 14
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       en,
    input  logic                       half_level,
    input  logic signed [BND_W-1:0]    bnd2_nxt,
    input  logic signed [WIDE_W-1:0]   w1_nxt,
    input  logic signed [WIDE_W-1:0]   w2_nxt,
    output logic                       q_bit,
    output logic signed [WIDE_W+1:0]   combined
);
    localparam int R     = ref_mag(BND_W);
    localparam int OUT_W = WIDE_W + 2;
    localparam logic signed [OUT_W-1:0] LVL_FULL = OUT_W'(R);
    localparam logic signed [OUT_W-1:0] LVL_HALF = OUT_W'(R / 2);

    logic                    q_c;
    logic signed [OUT_W-1:0] lvl, q_lvl, comb_c;

    always_comb begin
        q_c    = !bnd2_nxt[BND_W-1];
        lvl    = half_level ? LVL_HALF : LVL_FULL;
        q_lvl  = q_c ? lvl : -lvl;
        comb_c = OUT_W'(w1_nxt) + (OUT_W'(w2_nxt) <<< 1) + q_lvl;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_bit    <= 1'b0;
            combined <= '0;
        end else if (en) begin
            q_bit    <= q_c;
            combined <= comb_c;
        end
    end

    assert_hold_out_R9: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(combined) && $stable(q_bit)));
endmodule

// File: rtl/hyb_dsm_top.sv
module hyb_dsm_top
    import hyb_pkg::*;
#(
    parameter int BND_W  = 10,
    parameter int WIDE_W = 14
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [BND_W-1:0]  in_sample,
    input  logic                     step_double,
    input  logic                     half_level,
    output logic                     q_bit,
    output logic signed [BND_W-1:0]  bnd1,
    output logic signed [BND_W-1:0]  bnd2,
    output logic signed [WIDE_W-1:0] wide1,
    output logic signed [WIDE_W-1:0] wide2,
    output logic signed [WIDE_W+1:0] combined,
    output logic [1:0]               ovl_hi,
    output logic [1:0]               ovl_lo,
    output logic [1:0]               wide_ovf
);
    localparam int N_STG  = 2;
    localparam int CALC_W = BND_W + 2;
    localparam int R      = ref_mag(BND_W);
    localparam logic signed [CALC_W-1:0] R_C = CALC_W'(R);

    logic signed [CALC_W-1:0] x_ext;
    logic signed [CALC_W-1:0] stg_in   [N_STG];
    logic signed [CALC_W-1:0] stg_corr [N_STG];
    logic signed [BND_W-1:0]  bnd_q    [N_STG];
    logic signed [BND_W-1:0]  bnd_nxt  [N_STG];
    logic signed [WIDE_W-1:0] wide_q   [N_STG];
    logic signed [WIDE_W-1:0] wide_nxt [N_STG];

    // Input clamp to [-R, +R].
    always_comb begin
        x_ext = CALC_W'(in_sample);
        if (x_ext > R_C)       stg_in[0] = R_C;
        else if (x_ext < -R_C) stg_in[0] = -R_C;
        else                   stg_in[0] = x_ext;
        // Cascade through the bounded path only, using the pre-update value.
        stg_in[1] = CALC_W'(bnd_q[0]);
    end

    for (genvar k = 0; k < N_STG; k++) begin : g_stage
        hyb_bounded_stage #(.BND_W(BND_W), .CALC_W(CALC_W)) u_bnd (
            .clk         (clk),
            .rst         (rst),
            .en          (in_valid),
            .u           (stg_in[k]),
            .step_double (step_double),
            .acc         (bnd_q[k]),
            .acc_nxt     (bnd_nxt[k]),
            .corr        (stg_corr[k]),
            .hi          (ovl_hi[k]),
            .lo          (ovl_lo[k])
        );
        hyb_wide_acc #(.WIDE_W(WIDE_W), .CALC_W(CALC_W)) u_wide (
            .clk     (clk),
            .rst     (rst),
            .en      (in_valid),
            .corr    (stg_corr[k]),
            .acc     (wide_q[k]),
            .acc_nxt (wide_nxt[k]),
            .ovf     (wide_ovf[k])
        );
    end

    hyb_out_stage #(.BND_W(BND_W), .WIDE_W(WIDE_W)) u_out (
        .clk        (clk),
        .rst        (rst),
        .en         (in_valid),
        .half_level (half_level),
        .bnd2_nxt   (bnd_nxt[1]),
        .w1_nxt     (wide_nxt[0]),
        .w2_nxt     (wide_nxt[1]),
        .q_bit      (q_bit),
        .combined   (combined)
    );

    assign bnd1  = bnd_q[0];
    assign bnd2  = bnd_q[1];
    assign wide1 = wide_q[0];
    assign wide2 = wide_q[1];

    assert_q_follows_sign_R6: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (q_bit == !bnd2[BND_W-1]));
    assert_hi_credits_wide_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (!ovl_hi[0] || wide_ovf[0] || (wide1 > $past(wide1))));
endmodule

// File: tb/hyb_dsm_top_bench.sv
module hyb_dsm_top_bench;
    localparam int RR   = 256;
    localparam int WMAX = 8191;
    localparam int WMIN = -8192;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [9:0] in_sample = '0;
    logic step_double = 1'b0;
    logic half_level = 1'b0;
    logic q_bit;
    logic signed [9:0] bnd1, bnd2;
    logic signed [13:0] wide1, wide2;
    logic signed [15:0] combined;
    logic [1:0] ovl_hi, ovl_lo, wide_ovf;

    int n_vec = 0;
    int n_bad = 0;
    int m_a[2], m_d[2], m_hi[2], m_lo[2], m_ovf[2];
    int m_q, m_comb;

    always #4 clk = ~clk;

    hyb_dsm_top u_hyb_dsm_top (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .step_double(step_double), .half_level(half_level), .q_bit(q_bit),
        .bnd1(bnd1), .bnd2(bnd2), .wide1(wide1), .wide2(wide2),
        .combined(combined), .ovl_hi(ovl_hi), .ovl_lo(ovl_lo), .wide_ovf(wide_ovf)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int k = 0; k < 2; k++) begin
            m_a[k] = 0; m_d[k] = 0; m_hi[k] = 0; m_lo[k] = 0; m_ovf[k] = 0;
        end
        m_q = 0; m_comb = 0;
    endtask

    // Reference update from the requirement equations.
    task automatic model_step(input int x);
        int u[2];
        int p, s, c, sum, lvl;
        u[0] = (x > RR) ? RR : ((x < -RR) ? -RR : x);   // R10 clamp
        u[1] = m_a[0];                                  // R5 pre-update stage-1 value
        s = step_double ? 2 * RR : RR;                  // R4
        for (int k = 0; k < 2; k++) begin
            p = m_a[k] + u[k];
            m_hi[k] = (p > RR) ? 1 : 0;                 // R1
            m_lo[k] = (p < -RR) ? 1 : 0;
            c = m_hi[k] ? s : (m_lo[k] ? -s : 0);       // R2
            m_a[k] = p - c;
            sum = m_d[k] + c;                           // R7
            if (sum > WMAX) begin m_d[k] = WMAX; m_ovf[k] = 1; end
            else if (sum < WMIN) begin m_d[k] = WMIN; m_ovf[k] = 1; end
            else m_d[k] = sum;
        end
        m_q = (m_a[1] >= 0) ? 1 : 0;                    // R6
        lvl = half_level ? RR / 2 : RR;
        m_comb = m_d[0] + 2 * m_d[1] + (m_q ? lvl : -lvl);  // R8
    endtask

    task automatic compare_all();
        chk("R3 bnd1", int'(bnd1), m_a[0]);
        chk("R5 bnd2", int'(bnd2), m_a[1]);
        chk("R2 wide1", int'(wide1), m_d[0]);
        chk("R2 wide2", int'(wide2), m_d[1]);
        chk("R1 ovl_hi", int'(ovl_hi), m_hi[0] + 2 * m_hi[1]);
        chk("R1 ovl_lo", int'(ovl_lo), m_lo[0] + 2 * m_lo[1]);
        chk("R7 wide_ovf", int'(wide_ovf), m_ovf[0] + 2 * m_ovf[1]);
        chk("R6 q_bit", int'(q_bit), m_q);
        chk("R8 combined", int'(combined), m_comb);
        chk("R3 bnd1 in range", (bnd1 <= RR && bnd1 >= -RR) ? 1 : 0, 1);
        chk("R3 bnd2 in range", (bnd2 <= RR && bnd2 >= -RR) ? 1 : 0, 1);
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic apply(input int x, input bit v);
        in_sample = 10'(x);
        in_valid  = v;
        @(negedge clk);
        if (v) model_step(x);   // with v low the model holds: R9
        compare_all();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_clear();
        compare_all();          // R9 reset state
    endtask

    initial begin
        #(200000 * 8);
        n_bad++;
        $display("FAIL R9 watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        for (int mode = 0; mode < 4; mode++) begin
            step_double = mode[0];   // R4
            half_level  = mode[1];   // R6
            // DC at the positive rail, clamped (R10), drives wide1 into saturation (R7)
            do_reset();
            for (int i = 0; i < 60; i++) apply(511, 1'b1);
            for (int i = 0; i < 3; i++) apply(-300, 1'b0);   // ignored: R9
            // DC at the negative side
            do_reset();
            for (int i = 0; i < 60; i++) apply(-400, 1'b1);
            // Full-scale sine
            do_reset();
            for (int i = 0; i < 200; i++)
                apply($rtoi(256.0 * $sin(2.0 * 3.14159265 * i / 37.0)), 1'b1);
            // Sweep over every input code with periodic idle cycles
            do_reset();
            for (int x = -512; x < 512; x++) apply(x, (x % 5) != 0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule